// File: doc/BRIEF.md
# Snooping MSI Cache-Line Controller

This block keeps the coherence state of one line of a write-back cache that shares a snooping bus with other caches. The line is always Invalid, Shared or Modified. On the processor side it takes read and write requests that come with a tag-match flag. Requests that the line can serve without the bus complete in the same cycle. All other requests win the bus through a request/grant handshake. The block then issues a read miss, a write miss or an invalidate, and it keeps the bus until the bus responder acknowledges. Other caches receive an invalidate before the writer is allowed to proceed, so the bus puts every write in order.

On the bus side it watches read-miss, write-miss and invalidate transactions from other caches. A Modified copy is the only up-to-date one, so when it is snooped the block raises a one-cycle data flush request, which supplies or writes back the data. The line then drops to Shared or Invalid. A flush is also raised for a Modified victim when a request with no tag match replaces the line. The lower level therefore always holds current data while the line is Shared.

A three-state sequencer drives the processor side. In IDLE, requests are accepted or completed locally. ARB requests the bus and waits for the grant. HOLD owns the bus and drives the command until the acknowledge arrives. Transitions: IDLE to ARB on a request that needs the bus. ARB to HOLD on grant. HOLD to IDLE on acknowledge. Line-state transitions: Invalid to Shared on an own read miss. Any state to Modified on an own write miss or invalidate. Modified to Shared on a snooped read miss. Shared or Modified to Invalid on a snooped write miss or invalidate.

Top module: `msi_line_ctrl`

## Requirements
- R1: During and right after reset, line_state is Invalid and bus_req, cpu_ready, flush_req and bus_cmd are all 0. Line encoding: Invalid=0, Shared=1, Modified=2; the value 3 never appears.
- R2: A read with cpu_hit=1 to a Shared or Modified line, or a write with cpu_hit=1 to a Modified line, raises cpu_ready in the same cycle. It raises no bus_req and leaves line_state unchanged.
- R3: A read with cpu_hit=0, or a read to an Invalid line, requests the bus. After the grant the block drives bus_cmd=1 (read miss), holding it stable, until bus_ack. cpu_ready rises in the acknowledge cycle, and the line is Shared afterwards.
- R4: A write with cpu_hit=0, or a write to an Invalid line, issues bus_cmd=2 (write miss) in the same way, and the line is Modified afterwards.
- R5: A write with cpu_hit=1 to a Shared line issues bus_cmd=3 (invalidate) and keeps the bus until bus_ack. cpu_ready stays low until that acknowledge, and the line is Modified afterwards.
- R6: A snooped read miss (snp_cmd=1, snp_hit=1) to a Modified line gives a one-cycle flush_req in the next cycle, and the line becomes Shared. A snooped read miss to a Shared line changes nothing.
- R7: A snooped write miss (snp_cmd=2) or invalidate (snp_cmd=3) with snp_hit=1 makes the line Invalid in the next cycle. flush_req pulses for that cycle only if the line was Modified.
- R8: A snoop with snp_hit=0, or any snoop to an Invalid line, leaves line_state unchanged and raises no flush_req.
- R9: In a cycle with snp_valid=1 and snp_hit=1, the block never raises cpu_ready. A request stalled this way is taken up again in the next cycle.
- R10: The bus command is chosen at grant time from the current line state. If a Shared line is invalidated while its upgrade waits for the grant, the block issues a write miss (bus_cmd=2) instead of an invalidate.
- R11: A request with cpu_hit=0 while the line is Modified raises flush_req for one cycle, in the first cycle after the grant, to write back the victim.
- R12: bus_req stays high from the first cycle after a bus-needing request until the acknowledge cycle. bus_cmd is 0 whenever the block does not hold the bus, including while it waits for the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present; held with its fields until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_hit | input | 1 | Tag of the request matches the held line |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Issued transaction: 0 none, 1 read miss, 2 write miss, 3 invalidate |
| bus_ack | input | 1 | Transaction finished: data returned or all caches have received the invalidate |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped transaction, same encoding as bus_cmd |
| snp_hit | input | 1 | Snooped address matches the held line |
| flush_req | output | 1 | One-cycle request to supply or write back the line's data |
| line_state | output | 2 | Current line state: 0 Invalid, 1 Shared, 2 Modified |

## Verification
The properties assume a well-behaved bus. No snoop arrives while this block holds the bus or in the cycle it is granted. bus_ack comes only while a command is being driven. The processor holds its request stable until cpu_ready. The bench follows these rules by construction. It raises grant and acknowledge only after seeing bus_req, and it drives snoops only in the idle or waiting-for-grant phases. It drives each request from one falling edge until the cycle its completion is seen. Snoops in the same cycle as a local request, and snoops while an upgrade waits for the grant, are placed on purpose, because R9 and R10 depend on them.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_INVAL  = 2'd3
    } buscmd_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARB  = 2'd1,
        SQ_HOLD = 2'd2
    } seq_e;

endpackage

// File: rtl/msi_snoop_react.sv
module msi_snoop_react
    import msi_pkg::*;
(
    input  line_e   cur,
    input  logic    snp_valid,
    input  logic    snp_hit,
    input  buscmd_e snp_cmd,
    output logic    snp_seen,
    output line_e   snp_next,
    output logic    snp_flush
);
    always_comb begin
        snp_seen  = snp_valid && snp_hit;
        snp_next  = cur;
        snp_flush = 1'b0;
        if (snp_seen && snp_cmd != BC_NONE) begin
            unique case (cur)
                LN_MOD: begin
                    snp_flush = 1'b1;
                    snp_next  = (snp_cmd == BC_RDMISS) ? LN_SHR : LN_INV;
                end
                LN_SHR: begin
                    if (snp_cmd != BC_RDMISS) snp_next = LN_INV;
                end
                default: snp_next = cur;
            endcase
        end
    end
endmodule

// File: rtl/msi_req_decode.sv
module msi_req_decode
    import msi_pkg::*;
(
    input  line_e   cur,
    input  logic    is_write,
    input  logic    tag_hit,
    output logic    local_done,
    output buscmd_e need_cmd,
    output logic    victim
);
    logic present;

    always_comb begin
        present    = tag_hit && (cur != LN_INV);
        local_done = 1'b0;
        need_cmd   = BC_NONE;
        victim     = 1'b0;
        if (present && (!is_write || cur == LN_MOD)) begin
            local_done = 1'b1;
        end else if (present) begin
            need_cmd = BC_INVAL;
        end else begin
            need_cmd = is_write ? BC_WRMISS : BC_RDMISS;
            victim   = !tag_hit && (cur == LN_MOD);
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_valid,
    input  logic       cpu_write,
    input  logic       cpu_hit,
    output logic       cpu_ready,
    output logic       bus_req,
    input  logic       bus_gnt,
    output logic [1:0] bus_cmd,
    input  logic       bus_ack,
    input  logic       snp_valid,
    input  logic [1:0] snp_cmd,
    input  logic       snp_hit,
    output logic       flush_req,
    output logic [1:0] line_state
);
    seq_e    seq_q, seq_nx;
    line_e   line_q, line_nx;
    buscmd_e cmd_q, cmd_nx;
    logic    flush_q, flush_nx;
    logic    wr_q, hit_q, lat_en;
    logic    dec_wr, dec_hit;
    logic    dec_local, dec_victim;
    buscmd_e dec_cmd;
    logic    snp_seen, snp_flush;
    line_e   snp_next;

    assign dec_wr  = (seq_q == SQ_IDLE) ? cpu_write : wr_q;
    assign dec_hit = (seq_q == SQ_IDLE) ? cpu_hit   : hit_q;

    msi_req_decode u_dec (
        .cur        (line_q),
        .is_write   (dec_wr),
        .tag_hit    (dec_hit),
        .local_done (dec_local),
        .need_cmd   (dec_cmd),
        .victim     (dec_victim)
    );

    msi_snoop_react u_snp (
        .cur       (line_q),
        .snp_valid (snp_valid),
        .snp_hit   (snp_hit),
        .snp_cmd   (buscmd_e'(snp_cmd)),
        .snp_seen  (snp_seen),
        .snp_next  (snp_next),
        .snp_flush (snp_flush)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SQ_IDLE;
            line_q  <= LN_INV;
            cmd_q   <= BC_NONE;
            flush_q <= 1'b0;
            wr_q    <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            seq_q   <= seq_nx;
            line_q  <= line_nx;
            cmd_q   <= cmd_nx;
            flush_q <= flush_nx;
            if (lat_en) begin
                wr_q  <= cpu_write;
                hit_q <= cpu_hit;
            end
        end
    end

    // next state and outputs
    always_comb begin
        seq_nx    = seq_q;
        line_nx   = snp_next;
        cmd_nx    = cmd_q;
        flush_nx  = snp_flush;
        lat_en    = 1'b0;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        unique case (seq_q)
            SQ_IDLE: begin
                if (cpu_valid && !snp_seen) begin
                    if (dec_local) begin
                        cpu_ready = 1'b1;
                    end else begin
                        lat_en = 1'b1;
                        seq_nx = SQ_ARB;
                    end
                end
            end
            SQ_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    cmd_nx   = dec_cmd;
                    flush_nx = snp_flush || dec_victim;
                    seq_nx   = SQ_HOLD;
                end
            end
            SQ_HOLD: begin
                bus_req = 1'b1;
                bus_cmd = cmd_q;
                if (bus_ack) begin
                    cpu_ready = 1'b1;
                    line_nx   = (cmd_q == BC_RDMISS) ? LN_SHR : LN_MOD;
                    cmd_nx    = BC_NONE;
                    seq_nx    = SQ_IDLE;
                end
            end
            default: seq_nx = SQ_IDLE;
        endcase
    end

    assign flush_req  = flush_q;
    assign line_state = line_q;

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic [1:0] bus_cmd,
    input logic       bus_ack,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       snp_hit,
    input logic       flush_req,
    input logic [1:0] line_state
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        line_state != 2'd3); // R1
    AST_CMD_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> bus_req); // R12
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_cmd != 2'd0 && bus_ack)) |=> bus_req); // R12
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0 && !bus_ack) |=> $stable(bus_cmd)); // R3
    AST_RDMISS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd1 && bus_ack) |=> line_state == 2'd1); // R3
    AST_WRITE_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cmd == 2'd2 || bus_cmd == 2'd3) && bus_ack) |=> line_state == 2'd2); // R5
    AST_FLUSH_FROM_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(line_state) == 2'd2); // R6
    AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_hit && snp_cmd[1] && bus_cmd == 2'd0) |=> line_state == 2'd0); // R7
    AST_SNOOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_hit) |-> !cpu_ready); // R9
endmodule

bind msi_line_ctrl msi_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_ack    (bus_ack),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_hit    (snp_hit),
    .flush_req  (flush_req),
    .line_state (line_state)
);

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0, cpu_write = 1'b0, cpu_hit = 1'b0;
    logic       cpu_ready;
    logic       bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [1:0] bus_cmd;
    logic       snp_valid = 1'b0, snp_hit = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic       flush_req;
    logic [1:0] line_state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    msi_line_ctrl u_msi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_ack(bus_ack),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_hit(snp_hit),
        .flush_req(flush_req), .line_state(line_state)
    );

    // snp: 1 = snoop; op: write flag for requests, snooped command for snoops
    // ecmd: expected bus command (0 = completes locally)
    typedef struct packed {
        logic       snp;
        logic [1:0] op;
        logic       hit;
        logic [1:0] ecmd;
        logic [1:0] estate;
        logic       eflush;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 1'b1, 2'd1, 2'd1, 1'b0, 4'd3},  // R3 read to Invalid
        '{1'b0, 2'd0, 1'b1, 2'd0, 2'd1, 1'b0, 4'd2},  // R2 read hit Shared
        '{1'b0, 2'd1, 1'b1, 2'd3, 2'd2, 1'b0, 4'd5},  // R5 upgrade
        '{1'b0, 2'd1, 1'b1, 2'd0, 2'd2, 1'b0, 4'd2},  // R2 write hit Modified
        '{1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 1'b0, 4'd2},  // R2 read hit Modified
        '{1'b1, 2'd1, 1'b1, 2'd0, 2'd1, 1'b1, 4'd6},  // R6 snooped read, Modified
        '{1'b1, 2'd1, 1'b1, 2'd0, 2'd1, 1'b0, 4'd6},  // R6 snooped read, Shared
        '{1'b1, 2'd2, 1'b0, 2'd0, 2'd1, 1'b0, 4'd8},  // R8 tag mismatch
        '{1'b1, 2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 4'd7},  // R7 invalidate Shared
        '{1'b1, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0, 4'd8},  // R8 snoop to Invalid
        '{1'b0, 2'd1, 1'b0, 2'd2, 2'd2, 1'b0, 4'd4},  // R4 write, no tag match
        '{1'b1, 2'd2, 1'b1, 2'd0, 2'd0, 1'b1, 4'd7},  // R7 write miss on Modified
        '{1'b0, 2'd1, 1'b1, 2'd2, 2'd2, 1'b0, 4'd4},  // R4 write to Invalid
        '{1'b0, 2'd0, 1'b0, 2'd1, 2'd1, 1'b1, 4'd11}, // R11 victim write-back
        '{1'b1, 2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 4'd7},  // R7
        '{1'b0, 2'd0, 1'b0, 2'd1, 2'd1, 1'b0, 4'd3},  // R3 read, no tag match
        '{1'b0, 2'd1, 1'b1, 2'd3, 2'd2, 1'b0, 4'd5},  // R5
        '{1'b1, 2'd3, 1'b1, 2'd0, 2'd0, 1'b1, 4'd7},  // R7 invalidate on Modified
        '{1'b0, 2'd0, 1'b1, 2'd1, 2'd1, 1'b0, 4'd3}   // R3
    };

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_req(input logic wr, input logic hit, input int ecmd,
                          input int estate, input int eflush, input string tag);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_hit = hit;
        #1;
        if (ecmd == 0) begin
            chk(cpu_ready, 1, {tag, " local ready"});
            chk(bus_req, 0, {tag, " no bus_req"});
            @(negedge clk);
            cpu_valid = 1'b0;
        end else begin
            chk(cpu_ready, 0, {tag, " not ready before bus"});
            @(negedge clk);
            chk(bus_req, 1, {tag, " R12 bus_req while waiting"});
            chk(bus_cmd, 0, {tag, " R12 no cmd before grant"});
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            #1;
            chk(bus_cmd, ecmd, {tag, " bus_cmd"});
            chk(flush_req, eflush, {tag, " flush after grant"});
            chk(cpu_ready, 0, {tag, " R5 not ready before ack"});
            @(negedge clk);
            chk(bus_cmd, ecmd, {tag, " bus_cmd held"});
            chk(flush_req, 0, {tag, " flush one cycle"});
            bus_ack = 1'b1;
            #1;
            chk(cpu_ready, 1, {tag, " ready on ack"});
            @(negedge clk);
            bus_ack = 1'b0; cpu_valid = 1'b0;
            #1;
            chk(bus_req, 0, {tag, " bus released"});
        end
        chk(line_state, estate, {tag, " line_state"});
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic hit, input int estate,
                            input int eflush, input string tag);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_hit = hit;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0; snp_hit = 1'b0;
        #1;
        chk(flush_req, eflush, {tag, " flush"});
        chk(line_state, estate, {tag, " line_state"});
        @(negedge clk);
        chk(flush_req, 0, {tag, " flush one cycle"});
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 values during reset
        chk(line_state, 0, "R1 state in reset");
        chk(bus_req, 0, "R1 bus_req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_state, 0, "R1 state after reset");
        chk(bus_req, 0, "R1 bus_req after reset");
        chk(cpu_ready, 0, "R1 cpu_ready after reset");
        chk(flush_req, 0, "R1 flush_req after reset");
        chk(bus_cmd, 0, "R1 bus_cmd after reset");

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            if (VEC[i].snp)
                do_snoop(VEC[i].op, VEC[i].hit, VEC[i].estate, VEC[i].eflush, tag);
            else
                do_req(VEC[i].op[0], VEC[i].hit, VEC[i].ecmd, VEC[i].estate,
                       VEC[i].eflush, tag);
        end

        // R9: local read hit stalled by a same-cycle snoop (line is Shared)
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_hit = 1'b1;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_hit = 1'b1;
        #1;
        chk(cpu_ready, 0, "R9 stalled during snoop");
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0; snp_hit = 1'b0;
        #1;
        chk(cpu_ready, 1, "R9 completes after snoop");
        chk(bus_req, 0, "R9 no bus_req");
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(line_state, 1, "R9 line stays Shared");

        // R10: upgrade loses its copy while waiting for grant
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b1; cpu_hit = 1'b1;
        @(negedge clk);
        chk(bus_req, 1, "R10 waiting for grant");
        snp_valid = 1'b1; snp_cmd = 2'd3; snp_hit = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 2'd0; snp_hit = 1'b0;
        #1;
        chk(line_state, 0, "R10 invalidated while waiting");
        chk(bus_cmd, 0, "R12 no cmd while waiting");
        chk(bus_req, 1, "R12 bus_req still high");
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        #1;
        chk(bus_cmd, 2, "R10 write miss issued");
        bus_ack = 1'b1;
        #1;
        chk(cpu_ready, 1, "R10 ready on ack");
        @(negedge clk);
        bus_ack = 1'b0; cpu_valid = 1'b0;
        #1;
        chk(line_state, 2, "R10 ends Modified");
        chk(bus_cmd, 0, "R12 cmd cleared after ack");

        // R1: reset in the middle of a bus wait
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_hit = 1'b0;
        @(negedge clk);
        cpu_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bus_req, 0, "R1 bus_req after mid reset");
        chk(line_state, 0, "R1 state after mid reset");

        repeat (2) @(negedge clk);
        wrap_up();
    end

endmodule